// File: doc/BRIEF.md
# Fixed-Frequency Current Chopper Controller

This block holds the digital control of a constant-current chopper that drives a four-output unipolar stepper stage. One counter divides the system clock into a single chop period that all phases share. At each period boundary every phase latch turns on. A phase latch turns off when the current comparator of its winding pair trips, and it stays off until the next boundary. Because all phases share one boundary, the two winding pairs cannot beat against each other while the motor holds position.

Comparator trips go through a two-flop synchronizer. They are ignored during a blanking window at the start of each period, which masks the current spike that follows switch-on. A gate output is its latch ANDed with the phase-drive request, the enable input and a guard for its winding pair. Whenever the pair's requests change, the guard holds both outputs of that pair off for a set number of cycles, so complementary outputs never switch at the same moment. The analog comparator, the reference level and the power stage sit outside the block.

Top module: `chop_ctrl`

## Requirements
- R1: While `enable` is high, the period position counts 0 to PERIOD_CYC-1 and wraps, one step per clock. Each time the position is 0 there is a period start. The first enabled cycle is position 0.
- R2: At every period start, all four phase latches are set. The gate of a requested phase is high from the cycle after the start edge, unless a later requirement holds it off.
- R3: A synchronized trip of a winding pair clears both latches of that pair at an edge where the position is BLANK_CYC or more. Those gates then stay low until the next period start. The synchronized trip is the `trip` input delayed by two clock edges.
- R4: A synchronized trip seen at a position below BLANK_CYC has no effect. A trip still present when the position reaches BLANK_CYC clears the latch at that edge. With a trip held high, a requested gate is high for exactly BLANK_CYC cycles of each period.
- R5: A gate is never high unless its own bit of `drive_req` is high. Bit 0 is A, bit 1 is A-bar, bit 2 is B and bit 3 is B-bar.
- R6: When `enable` is low, all gates are low in that same cycle and all latches clear. The period position restarts at 0 once `enable` returns high.
- R7: In a cycle where the two request bits of a pair differ from their values at the previous edge, both gates of that pair are low. They also stay low for GAP_CYC further clock edges.
- R8: During reset and on the first cycle after it, all gates are low.
- R9: The two pairs are independent. `trip[0]` affects only gates 0 and 1, and `trip[1]` affects only gates 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (base oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low forces every gate off and restarts the period |
| drive_req | input | 4 | Phase-drive requests: A, A-bar, B, B-bar in bits 0..3 |
| trip | input | 2 | Comparator trips: bit 0 pair A, bit 1 pair B (asynchronous) |
| gate | output | 4 | Gate drive for A, A-bar, B, B-bar |

## Verification
The bench sweeps a trip pulse across every position of the period, at two pulse widths and under several request patterns. A design that counted the blanking window one cycle off, or that skipped a synchronizer stage, would then clear the latch one cycle early or late. A trip held across the end of blanking checks that the latch clears right at the boundary; a design that looked for a trip edge would never clear it. Requests change at spacings both shorter and longer than the gap, to check that the guard restarts on each new change and does not release early. Enable drops at arbitrary positions check that the period restarts from zero and does not resume mid-count.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int unsigned NUM_PHASE = 4;
    localparam int unsigned NUM_PAIR  = 2;

    // request bits of one winding pair
    typedef struct packed {
        logic on_bar;
        logic on_main;
    } pair_req_t;

    // winding pair that owns a phase output
    function automatic int unsigned pair_of(input int unsigned ph);
        return ph / 2;
    endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
    parameter int unsigned PERIOD_CYC = 16,
    parameter int unsigned BLANK_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic period_start,
    output logic blank_win
);
    localparam int unsigned CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

    logic [CW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pos <= '0;
        end else if (pos == CW'(PERIOD_CYC - 1)) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign period_start = enable && (pos == '0);
    assign blank_win    = enable && (pos < CW'(BLANK_CYC));

endmodule

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] trip_in,
    output logic [WIDTH-1:0] trip_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            trip_out <= '0;
        end else begin
            stage1   <= trip_in;
            trip_out <= stage1;
        end
    end

endmodule

// File: rtl/gap_guard.sv
module gap_guard
    import chop_pkg::*;
#(
    parameter int unsigned GAP_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  pair_req_t req,
    output logic      hold
);
    localparam int unsigned GW = $clog2(GAP_CYC + 1);

    pair_req_t     req_q;
    logic [GW-1:0] gap_cnt;
    logic          changed;

    assign changed = (req != req_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            gap_cnt <= '0;
        end else begin
            req_q <= req;
            if (changed) begin
                gap_cnt <= GW'(GAP_CYC);
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - 1'b1;
            end
        end
    end

    assign hold = changed || (gap_cnt != '0);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 16,
    parameter int unsigned BLANK_CYC  = PERIOD_CYC / 8,
    parameter int unsigned GAP_CYC    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [3:0] drive_req,
    input  logic [1:0] trip,
    output logic [3:0] gate
);
    logic                 period_start;
    logic                 blank_win;
    logic [NUM_PAIR-1:0]  trip_s;
    logic [NUM_PAIR-1:0]  pair_hold;
    logic [NUM_PHASE-1:0] phase_latch;

    chop_timebase #(
        .PERIOD_CYC(PERIOD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) timebase_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .period_start(period_start),
        .blank_win   (blank_win)
    );

    trip_sync #(
        .WIDTH(NUM_PAIR)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .trip_in (trip),
        .trip_out(trip_s)
    );

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        gap_guard #(
            .GAP_CYC(GAP_CYC)
        ) guard_i (
            .clk (clk),
            .rst (rst),
            .req (pair_req_t'(drive_req[2*p +: 2])),
            .hold(pair_hold[p])
        );
    end

    for (genvar ph = 0; ph < NUM_PHASE; ph++) begin : g_phase
        localparam int unsigned PR = pair_of(ph);

        always_ff @(posedge clk) begin
            if (rst || !enable) begin
                phase_latch[ph] <= 1'b0;
            end else if (period_start) begin
                phase_latch[ph] <= 1'b1;
            end else if (!blank_win && trip_s[PR]) begin
                phase_latch[ph] <= 1'b0;
            end
        end

        assign gate[ph] = enable && phase_latch[ph] && drive_req[ph] && !pair_hold[PR];
    end

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [3:0] drive_req,
    input logic [3:0] gate,
    input logic       period_start,
    input logic       blank_win,
    input logic [3:0] phase_latch
);
    // R1: two period starts are never adjacent
    a_r1_start_spacing: assert property (@(posedge clk) disable iff (rst)
        (enable && period_start) |=> !period_start);

    // R2: every latch is set after a start edge
    a_r2_set_on_start: assert property (@(posedge clk) disable iff (rst)
        (enable && period_start) |=> (phase_latch == 4'hF));

    for (genvar i = 0; i < 4; i++) begin : g_ph
        // R4: blanking keeps a set latch set
        a_r4_blank_hold: assert property (@(posedge clk) disable iff (rst)
            (enable && blank_win && phase_latch[i]) |=> phase_latch[i]);
        // R3: a cleared latch stays cleared until a period start
        a_r3_off_until_start: assert property (@(posedge clk) disable iff (rst)
            (enable && !period_start && !phase_latch[i]) |=> !phase_latch[i]);
    end

    // R5: no gate without its request
    a_r5_gate_needs_req: assert property (@(posedge clk) disable iff (rst)
        (gate & ~drive_req) == 4'h0);

    // R6: disable forces all gates off
    a_r6_enable_off: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (gate == 4'h0));

    for (genvar p = 0; p < 2; p++) begin : g_pr
        // R7: a request change blanks the pair in the same cycle
        a_r7_change_off: assert property (@(posedge clk) disable iff (rst)
            (drive_req[2*p +: 2] != $past(drive_req[2*p +: 2])) |-> (gate[2*p +: 2] == 2'b00));
    end

    // R8: latches come out of reset cleared
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_latch == 4'h0));

endmodule

bind chop_ctrl chop_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .drive_req   (drive_req),
    .gate        (gate),
    .period_start(period_start),
    .blank_win   (blank_win),
    .phase_latch (phase_latch)
);

// File: tb/chop_ctrl_tb.sv
module chop_ctrl_tb_top;
    localparam int P   = 16;
    localparam int B   = 2;
    localparam int GAP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] req = 4'h0;
    logic [1:0] trip = 2'b00;
    logic [3:0] gate;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    chop_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(B), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst(rst), .enable(en), .drive_req(req), .trip(trip), .gate(gate)
    );

    // behavioural expectation built from the requirements
    int         m_n;
    bit [1:0]   m_s1, m_s2;
    bit [3:0]   m_lat;
    bit [3:0]   m_rq;
    int         m_gap [2];

    always @(posedge clk) begin
        if (rst) begin
            m_n = 0; m_s1 = 0; m_s2 = 0; m_lat = 0; m_rq = 0;
            m_gap[0] = 0; m_gap[1] = 0;
        end else begin
            int pos;
            pos = m_n % P;
            for (int ph = 0; ph < 4; ph++) begin
                if (!en) m_lat[ph] = 0;
                else if (pos == 0) m_lat[ph] = 1;
                else if (pos >= B && m_s2[ph/2]) m_lat[ph] = 0;
            end
            m_s2 = m_s1;
            m_s1 = trip;
            for (int p = 0; p < 2; p++) begin
                if (req[2*p +: 2] != m_rq[2*p +: 2]) m_gap[p] = GAP;
                else if (m_gap[p] > 0) m_gap[p] = m_gap[p] - 1;
            end
            m_rq = req;
            m_n = en ? m_n + 1 : 0;
        end
    end

    task automatic compare();
        for (int ph = 0; ph < 4; ph++) begin
            int p;
            bit chg, exp;
            string tag;
            p   = ph / 2;
            chg = (req[2*p +: 2] != m_rq[2*p +: 2]);
            exp = !rst && en && m_lat[ph] && req[ph] && !chg && (m_gap[p] == 0);
            if (rst) tag = "R8";
            else if (!en) tag = "R6";
            else if (chg || m_gap[p] != 0) tag = "R7";
            else if (!req[ph]) tag = "R5";
            else if (m_lat[ph]) tag = "R2";
            else tag = "R3";
            checks++;
            if (gate[ph] !== exp) begin
                failures++;
                $display("FAIL %s phase=%0d t=%0t actual=%b expected=%b", tag, ph, $time, gate[ph], exp);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic expect_count(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #4ms;
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();                    // R8 while in reset
        rst = 1'b0;
        step();                               // R8 first cycle after reset
        expect_count("R8", int'(gate), 0);

        // R4 / R1 / R9: pair B trip held, pair A free
        en = 1'b1; req = 4'b0101; trip = 2'b10;
        repeat (3*P) step();
        begin
            int hi_a = 0, hi_b = 0;
            for (int k = 0; k < 4*P; k++) begin
                step();
                hi_a += gate[0];
                hi_b += gate[2];
            end
            expect_count("R9", hi_a, 4*P);
            expect_count("R4", hi_b, 4*B);
        end
        trip = 2'b00;

        // R3 / R4 sweep: trip pulse at each position, two widths, several patterns
        for (int pi = 0; pi < 4; pi++) begin
            logic [3:0] pat;
            pat = (pi == 0) ? 4'b0101 : (pi == 1) ? 4'b1010 : (pi == 2) ? 4'b0110 : 4'b1111;
            for (int w = 1; w <= 3; w += 2) begin
                for (int t = 0; t < P; t++) begin
                    en = 1'b0; step();
                    en = 1'b1; req = pat;
                    repeat (GAP + 2) step();
                    for (int k = 0; k < 2*P; k++) begin
                        trip = (k >= t && k < t + w) ? ((t % 2 == 0) ? 2'b11 : 2'b01) : 2'b00;
                        step();
                    end
                    trip = 2'b00;
                end
            end
        end

        // R7: request changes at varied spacing
        en = 1'b1;
        for (int sp = 1; sp <= 6; sp++) begin
            for (int k = 0; k < 6; k++) begin
                req = {req[2], req[3], req[0], ~req[1]};
                repeat (sp) step();
            end
            repeat (P) step();
        end

        // R6: enable drops at arbitrary positions, some with trips active
        req = 4'b1111;
        for (int d = 0; d < P + 3; d++) begin
            repeat (d) step();
            en = 1'b0;
            trip = d[0] ? 2'b01 : 2'b00;
            repeat (1 + d % 3) step();
            en = 1'b1;
            trip = 2'b00;
            step();
        end

        // R2 / R3: trip held on both pairs across enable re-entry
        trip = 2'b11;
        repeat (3*P) step();
        trip = 2'b00;
        repeat (2*P) step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule